// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block interprets command bytes that a host writes to a parallel NOR-style flash and steps through the multi-cycle write sequences of a command-user-interface flash. Behind it sits an on-chip byte array that stands in for the flash cells. A sequence can program one location, erase one block, or stream a counted burst of words into the array. Other commands switch the read path. A read then returns array data, the 8-bit status register, the identifier codes or the query table.

The host side is a single request channel with valid/ready handshaking. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The host must hold every request field stable while `req_valid` is high and `req_ready` is low. The block lowers `req_ready` only while a block erase is sweeping the array, one byte per cycle. The response channel has no back-pressure. `rsp_valid` pulses for one cycle, one cycle after a read is accepted, and `rsp_data` holds the registered result.

The `wr_protect` input turns program and erase operations into status error reports, and the array is left unchanged. The `big_endian` input selects the byte order of multi-byte data transfers.

Top module: `nor_cmd_sequencer`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, the status register is 0x00 and the sequencer is in read-array mode with no command pending.
- R2: Each accepted read produces `rsp_valid` high for exactly one cycle, on the cycle after acceptance. In read-array mode, an access of 1, 2 or 4 bytes (`req_size` 0, 1, 2) returns the bytes starting at `req_addr`. With `big_endian` low, the byte at `req_addr` occupies bits 7:0. With `big_endian` high, it occupies the most significant byte of the access. Write data uses the same mapping.
- R3: A command byte (write data bits 7:0) of 0x10 or 0x40 arms a single program. The next write stores its data at its address and width, and sets status bit 7. Reads keep returning status until a read-array command (0xFF, 0xF0 or 0x00) is written.
- R4: The command 0x20 followed by 0xD0 erases the block of BLK_BYTES bytes that contains the address, with the block base equal to the address with its low log2(BLK_BYTES) bits cleared. The block is filled with 0xFF at one byte per cycle. Status bit 7 is clear during the sweep and set when it ends.
- R5: After 0x20, a second write of any value other than 0xD0 leaves the array unchanged and returns to read-array mode.
- R6: The command 0xE8 sets status bit 7 and starts a buffered write. The next write gives a count N, taken from the low 8*DEV_BYTES bits of the data. The next N+1 writes store data. The write after them must be 0xD0 to end the sequence; any other value returns to read-array mode.
- R7: With `wr_protect` high, nothing is stored. A program or buffered data write sets status bits 4 and 7 (0x90). An erase confirm sets status bits 5 and 7 (0xA0) and starts no sweep.
- R8: While a command of 0x10, 0x20, 0x40, 0x60, 0x70 or 0xE8 is in force, reads return the status byte in the low byte of every DEV_BYTES-wide lane, truncated to the access size.
- R9: After 0x90, a read at index `req_addr >> log2(BANK_BYTES)` returns MFR_ID for index 0, DEV_ID for index 1 and 0 for any other index. The value is replicated in every DEV_BYTES-wide lane and truncated to the access size.
- R10: After 0x98, reads return a query byte per index, replicated like R9. The values are 0x51, 0x52 and 0x59 at indices 0x10, 0x11 and 0x12; 0x01 at 0x13; ADDR_W at 0x27; 0x01 at 0x2C; the block count minus one at 0x2D; and 0 elsewhere. Only a write of 0xFF leaves query mode; other writes are ignored.
- R11: The command 0x50 clears the status register and selects read-array mode. 0x70 selects status read. Any command byte not listed in R3 to R12 selects read-array mode.
- R12: After 0x60, a write of 0xD0 or 0x01 sets status bit 7 and ends the sequence with the status read still selected. Any other value returns to read-array mode.
- R13: `req_ready` is low for exactly BLK_BYTES cycles after an accepted erase confirm, and at no other time. A request held during that window is accepted when the sweep ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian | input | 1 | Byte order of multi-byte data transfers |
| wr_protect | input | 1 | Turns program and erase into error reports |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| req_wdata | input | 32 | Write data; bits 7:0 carry command bytes |
| rsp_valid | output | 1 | Read data valid for one cycle |
| rsp_data | output | 32 | Registered read data |

## Verification
The bench erases every block through an address in the middle of the block. A design that masked the block base wrongly would leave bytes unerased or erase the wrong ones, and an off-by-one sweep counter would change the measured count of stall cycles. The buffered write is given a count with bits set above the device width, so a design without the mask would treat the confirm byte as data and overwrite the next location. Array readback covers both byte orders at every width over programmed and erased regions. The identifier and query indices are swept in full, and writes that query mode must ignore are issued to confirm they change neither the mode nor the array. The protected program, erase and buffered cases are checked for status bits set and array content unchanged, which exposes a design that stores anyway or starts a sweep.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_PROG, PH_ERASE, PH_SWEEP, PH_LOCK,
    PH_COUNT, PH_DATA, PH_CONFIRM, PH_QUERY
  } phase_t;

  localparam logic [7:0] OP_NONE      = 8'h00;
  localparam logic [7:0] OP_LOCK_ALT  = 8'h01;
  localparam logic [7:0] OP_PROG_A    = 8'h10;
  localparam logic [7:0] OP_ERASE     = 8'h20;
  localparam logic [7:0] OP_PROG_B    = 8'h40;
  localparam logic [7:0] OP_CLR       = 8'h50;
  localparam logic [7:0] OP_LOCK      = 8'h60;
  localparam logic [7:0] OP_STAT      = 8'h70;
  localparam logic [7:0] OP_IDENT     = 8'h90;
  localparam logic [7:0] OP_QUERY     = 8'h98;
  localparam logic [7:0] OP_CONFIRM   = 8'hD0;
  localparam logic [7:0] OP_BUFFER    = 8'hE8;
  localparam logic [7:0] OP_ARRAY_ALT = 8'hF0;
  localparam logic [7:0] OP_ARRAY     = 8'hFF;

  function automatic int nbytes(logic [1:0] sz);
    case (sz)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic [7:0] qry_byte(logic [7:0] idx, int addr_w, int blocks);
    case (idx)
      8'h10:   return 8'h51;
      8'h11:   return 8'h52;
      8'h12:   return 8'h59;
      8'h13:   return 8'h01;
      8'h27:   return 8'(addr_w);
      8'h2C:   return 8'h01;
      8'h2D:   return 8'(blocks - 1);
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/nor_seq_store.sv
module nor_seq_store #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              big_endian,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic [31:0]       wr_data,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] clr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        rd_size,
  output logic [31:0]       rd_data
);
  import nor_seq_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  // bit lane of the i-th byte of an n-byte access
  function automatic int lane(int i, int n, logic be);
    return be ? (n - 1 - i) : i;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < 4; i++) begin
        if (i < nbytes(wr_size))
          mem[ADDR_W'(wr_addr + ADDR_W'(i))] <=
            wr_data[8*lane(i, nbytes(wr_size), big_endian) +: 8];
      end
    end
    if (clr_en) mem[clr_addr] <= 8'hFF;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < nbytes(rd_size))
        rd_data[8*lane(i, nbytes(rd_size), big_endian) +: 8] =
          mem[ADDR_W'(rd_addr + ADDR_W'(i))];
    end
  end

endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl #(
  parameter int ADDR_W    = 8,
  parameter int BLK_BYTES = 16,
  parameter int DEV_BYTES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_acc,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [31:0]         wr_data,
  input  logic                wr_protect,
  output nor_seq_pkg::phase_t phase,
  output logic [7:0]          cmd,
  output logic [7:0]          status,
  output logic                mem_we,
  output logic                clr_en,
  output logic [ADDR_W-1:0]   clr_addr
);
  import nor_seq_pkg::*;

  localparam int CNT_W = 8 * DEV_BYTES;
  localparam int OFS_W = $clog2(BLK_BYTES);

  logic [7:0]        c;
  logic [CNT_W-1:0]  words;
  logic [OFS_W-1:0]  sweep_ofs;
  logic [ADDR_W-1:0] base, blk_base;

  assign c        = wr_data[7:0];
  assign blk_base = {wr_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign mem_we   = wr_acc && !wr_protect && (phase == PH_PROG || phase == PH_DATA);
  assign clr_en   = (phase == PH_SWEEP);
  assign clr_addr = base | ADDR_W'(sweep_ofs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cmd       <= OP_NONE;
      status    <= 8'h00;
      words     <= '0;
      sweep_ofs <= '0;
      base      <= '0;
    end else if (phase == PH_SWEEP) begin
      sweep_ofs <= sweep_ofs + 1'b1;
      if (sweep_ofs == OFS_W'(BLK_BYTES - 1)) begin
        phase     <= PH_IDLE;
        status[7] <= 1'b1;
      end
    end else if (wr_acc) begin
      case (phase)
        PH_IDLE: begin
          case (c)
            OP_PROG_A, OP_PROG_B: begin cmd <= c; phase <= PH_PROG; end
            OP_ERASE:  begin cmd <= c; phase <= PH_ERASE; end
            OP_LOCK:   begin cmd <= c; phase <= PH_LOCK; end
            OP_QUERY:  begin cmd <= c; phase <= PH_QUERY; end
            OP_BUFFER: begin cmd <= c; status[7] <= 1'b1; phase <= PH_COUNT; end
            OP_STAT, OP_IDENT: cmd <= c;
            OP_CLR:    begin status <= 8'h00; cmd <= OP_NONE; end
            default:   cmd <= OP_NONE;
          endcase
        end
        PH_PROG: begin
          if (wr_protect) status[4] <= 1'b1;
          status[7] <= 1'b1;
          phase     <= PH_IDLE;
        end
        PH_ERASE: begin
          if (c == OP_CONFIRM && wr_protect) begin
            status[5] <= 1'b1;
            status[7] <= 1'b1;
            phase     <= PH_IDLE;
          end else if (c == OP_CONFIRM) begin
            base      <= blk_base;
            sweep_ofs <= '0;
            status[7] <= 1'b0;
            phase     <= PH_SWEEP;
          end else begin
            cmd   <= OP_NONE;
            phase <= PH_IDLE;
          end
        end
        PH_LOCK: begin
          if (c == OP_CONFIRM || c == OP_LOCK_ALT) status[7] <= 1'b1;
          else cmd <= OP_NONE;
          phase <= PH_IDLE;
        end
        PH_COUNT: begin
          words <= wr_data[CNT_W-1:0];
          phase <= PH_DATA;
        end
        PH_DATA: begin
          if (wr_protect) status[4] <= 1'b1;
          status[7] <= 1'b1;
          if (words == '0) phase <= PH_CONFIRM;
          else words <= words - 1'b1;
        end
        PH_CONFIRM: begin
          if (c == OP_CONFIRM) status[7] <= 1'b1;
          else cmd <= OP_NONE;
          phase <= PH_IDLE;
        end
        PH_QUERY: begin
          if (c == OP_ARRAY) begin
            cmd   <= OP_NONE;
            phase <= PH_IDLE;
          end
        end
        default: begin
          cmd   <= OP_NONE;
          phase <= PH_IDLE;
        end
      endcase
    end
  end

  // R4: the ready bit stays low for the whole sweep
  assert_sweep_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SWEEP) |-> !status[7]);

  // R4: the last swept byte hands control back with ready set
  assert_sweep_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SWEEP && sweep_ofs == OFS_W'(BLK_BYTES - 1)) |=> (phase == PH_IDLE && status[7]));

  // R11: the clear command empties status and drops any pending command
  assert_clear_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && phase == PH_IDLE && c == OP_CLR) |=> (status == 8'h00 && cmd == OP_NONE));

endmodule

// File: rtl/nor_seq_resp.sv
module nor_seq_resp #(
  parameter int          ADDR_W     = 8,
  parameter int          BLK_BYTES  = 16,
  parameter int          BANK_BYTES = 4,
  parameter int          DEV_BYTES  = 2,
  parameter logic [15:0] MFR_ID     = 16'h0089,
  parameter logic [15:0] DEV_ID     = 16'h0018
) (
  input  logic [7:0]        cmd,
  input  logic [7:0]        status,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [31:0]       array_data,
  output logic [31:0]       data_out
);
  import nor_seq_pkg::*;

  localparam int LANE_W = 8 * DEV_BYTES;
  localparam int LANES  = 4 / DEV_BYTES;
  localparam int SHIFT  = $clog2(BANK_BYTES);
  localparam int BLOCKS = (1 << ADDR_W) / BLK_BYTES;

  logic [ADDR_W-1:0] idx_full;
  logic [7:0]        idx;
  logic [LANE_W-1:0] lane_val;
  logic [31:0]       wide, mask;

  assign idx_full = addr >> SHIFT;
  assign idx      = 8'(idx_full);

  always_comb begin
    case (cmd)
      OP_IDENT: lane_val = (idx == 8'd0) ? LANE_W'(MFR_ID) :
                           (idx == 8'd1) ? LANE_W'(DEV_ID) : '0;
      OP_QUERY: lane_val = LANE_W'(qry_byte(idx, ADDR_W, BLOCKS));
      default:  lane_val = LANE_W'(status);
    endcase
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) wide[l*LANE_W +: LANE_W] = lane_val;
  end

  always_comb begin
    case (size)
      2'd0:    mask = 32'h0000_00FF;
      2'd1:    mask = 32'h0000_FFFF;
      default: mask = 32'hFFFF_FFFF;
    endcase
  end

  always_comb begin
    case (cmd)
      OP_PROG_A, OP_ERASE, OP_PROG_B, OP_LOCK, OP_STAT, OP_BUFFER,
      OP_IDENT, OP_QUERY: data_out = wide & mask;
      default:            data_out = array_data;
    endcase
  end

endmodule

// File: rtl/nor_cmd_sequencer.sv
module nor_cmd_sequencer #(
  parameter int          ADDR_W     = 8,
  parameter int          BLK_BYTES  = 16,
  parameter int          BANK_BYTES = 4,
  parameter int          DEV_BYTES  = 2,
  parameter logic [15:0] MFR_ID     = 16'h0089,
  parameter logic [15:0] DEV_ID     = 16'h0018
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  logic              wr_protect,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data
);
  import nor_seq_pkg::*;

  phase_t            phase;
  logic [7:0]        cmd, status;
  logic              wr_acc, rd_acc, mem_we, clr_en;
  logic [ADDR_W-1:0] clr_addr;
  logic [31:0]       array_data, read_val;

  assign req_ready = (phase != PH_SWEEP);
  assign wr_acc    = req_valid && req_ready && req_write;
  assign rd_acc    = req_valid && req_ready && !req_write;

  nor_seq_ctrl #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .DEV_BYTES(DEV_BYTES)) u_ctrl (
    .clk, .rst_n, .wr_acc, .wr_addr(req_addr), .wr_data(req_wdata), .wr_protect,
    .phase, .cmd, .status, .mem_we, .clr_en, .clr_addr
  );

  nor_seq_store #(.ADDR_W(ADDR_W)) u_store (
    .clk, .big_endian, .wr_en(mem_we), .wr_addr(req_addr), .wr_size(req_size),
    .wr_data(req_wdata), .clr_en, .clr_addr, .rd_addr(req_addr), .rd_size(req_size),
    .rd_data(array_data)
  );

  nor_seq_resp #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .BANK_BYTES(BANK_BYTES),
                 .DEV_BYTES(DEV_BYTES), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_resp (
    .cmd, .status, .addr(req_addr), .size(req_size), .array_data, .data_out(read_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) rsp_data <= read_val;
    end
  end

  // R2: one response per accepted read, exactly one cycle later
  assert_rsp_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);
  assert_rsp_only_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rsp_valid);

  // R7: protection keeps the host write port of the array closed
  assert_wp_no_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_protect |-> !mem_we);

  // R4: the sweep and a host store never share a cycle
  assert_single_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && clr_en));

  // R13: nothing is stored while the channel is stalled
  assert_stall_no_store_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !mem_we);

endmodule

// File: tb/tb_nor_cmd_sequencer.sv
`timescale 1ns/1ps
module tb_nor_cmd_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_endian = 1'b0;
  logic        wr_protect = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] mem_m [256];

  always #2 clk = ~clk;

  nor_cmd_sequencer dut (
    .clk, .rst_n, .big_endian, .wr_protect, .req_valid, .req_ready, .req_write,
    .req_addr, .req_size, .req_wdata, .rsp_valid, .rsp_data
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic int nb(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] model_rd(logic [7:0] a, logic [1:0] s, logic be);
    logic [31:0] r = '0;
    for (int i = 0; i < nb(s); i++)
      r[8*(be ? nb(s) - 1 - i : i) +: 8] = mem_m[8'(a + 8'(i))];
    return r;
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d, input logic be);
    for (int i = 0; i < nb(s); i++)
      mem_m[8'(a + 8'(i))] = d[8*(be ? nb(s) - 1 - i : i) +: 8];
  endtask

  function automatic logic [31:0] rep(logic [15:0] v, logic [1:0] s);
    logic [31:0] r = {v, v};
    return (s == 2'd0) ? (r & 32'hFF) : (s == 2'd1) ? (r & 32'hFFFF) : r;
  endfunction

  function automatic logic [7:0] qry_exp(int i);
    case (i)
      16'h10: return 8'h51;
      16'h11: return 8'h52;
      16'h12: return 8'h59;
      16'h13: return 8'h01;
      16'h27: return 8'd8;
      16'h2C: return 8'h01;
      16'h2D: return 8'd15;
      default: return 8'h00;
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = s; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [1:0] s, input logic [31:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = s;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    chk(tag, rsp_data, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", {31'b0, req_ready}, 32'd1);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    wr(8'h00, 2'd0, 32'h70);
    rdchk("R1 status zero", 8'h00, 2'd2, 32'h0);

    // R4 R13: erase every block through a mid-block address
    for (int b = 0; b < 16; b++) begin
      wr(8'(b*16 + 5), 2'd0, 32'h20);
      wr(8'(b*16 + 5), 2'd0, 32'hD0);
      n = 0;
      while (!req_ready) begin n++; @(negedge clk); end
      chk("R13 sweep stall cycles", n, 16);
      rdchk("R4 ready after sweep", 8'h00, 2'd0, 32'h80);
    end
    for (int i = 0; i < 256; i++) mem_m[i] = 8'hFF;
    // R13: a read held across a sweep is served after it
    wr(8'hF3, 2'd0, 32'h20);
    wr(8'hF3, 2'd0, 32'hD0);
    rdchk("R13 held read", 8'h00, 2'd2, 32'h0080_0080);
    wr(8'h00, 2'd0, 32'hFF);
    for (int a = 0; a < 256; a++) rdchk("R4 erased byte", 8'(a), 2'd0, 32'hFF);

    // R3 R2: single program sweeps over widths and byte orders
    big_endian = 1'b0;
    for (int a = 0; a < 64; a += 4) begin
      wr(8'(a), 2'd0, (a % 8 == 0) ? 32'h40 : 32'h10);
      wr(8'(a), 2'd2, 32'hA500_0000 ^ (32'(a) * 32'h0103_0507));
      model_wr(8'(a), 2'd2, 32'hA500_0000 ^ (32'(a) * 32'h0103_0507), 1'b0);
    end
    big_endian = 1'b1;
    for (int a = 64; a < 128; a += 2) begin
      wr(8'(a), 2'd0, 32'h40);
      wr(8'(a), 2'd1, 32'(16'h3C00 + a * 7));
      model_wr(8'(a), 2'd1, 32'(16'h3C00 + a * 7), 1'b1);
    end
    for (int a = 128; a < 144; a++) begin
      wr(8'(a), 2'd0, 32'h10);
      wr(8'(a), 2'd0, 32'(a ^ 8'h6B));
      model_wr(8'(a), 2'd0, 32'(a ^ 8'h6B), 1'b1);
    end
    // R3 R8: status replication while the program command is in force
    rdchk("R8 status x4", 8'h10, 2'd2, 32'h0080_0080);
    rdchk("R8 status x2", 8'h10, 2'd1, 32'h0000_0080);
    rdchk("R3 status x1", 8'h10, 2'd0, 32'h0000_0080);
    wr(8'h00, 2'd0, 32'hF0);
    for (int e = 0; e < 2; e++) begin
      big_endian = e[0];
      for (int a = 0; a < 160; a++) rdchk("R2 byte read", 8'(a), 2'd0, model_rd(8'(a), 2'd0, e[0]));
      for (int a = 0; a < 160; a += 2) rdchk("R2 half read", 8'(a), 2'd1, model_rd(8'(a), 2'd1, e[0]));
      for (int a = 0; a < 160; a += 4) rdchk("R2 word read", 8'(a), 2'd2, model_rd(8'(a), 2'd2, e[0]));
    end
    big_endian = 1'b0;

    // R5: erase aborted by a wrong second byte and by 0xFF
    wr(8'h20, 2'd0, 32'h20);
    wr(8'h20, 2'd0, 32'h12);
    chk("R5 no stall", {31'b0, req_ready}, 32'd1);
    rdchk("R5 block kept", 8'h20, 2'd2, model_rd(8'h20, 2'd2, 1'b0));
    wr(8'h24, 2'd0, 32'h20);
    wr(8'h24, 2'd0, 32'hFF);
    rdchk("R5 abort by FF", 8'h24, 2'd2, model_rd(8'h24, 2'd2, 1'b0));

    // R6: buffered write, count carries bits above the device width
    wr(8'h90, 2'd0, 32'hE8);
    wr(8'h90, 2'd2, 32'h0001_0003);
    for (int k = 0; k < 4; k++) begin
      wr(8'(8'h90 + 4*k), 2'd2, 32'hC0DE_0000 + 32'(k));
      model_wr(8'(8'h90 + 4*k), 2'd2, 32'hC0DE_0000 + 32'(k), 1'b0);
    end
    wr(8'hA0, 2'd0, 32'hD0);
    rdchk("R6 status after confirm", 8'h00, 2'd2, 32'h0080_0080);
    wr(8'h00, 2'd0, 32'hFF);
    for (int k = 0; k < 4; k++)
      rdchk("R6 buffered data", 8'(8'h90 + 4*k), 2'd2, model_rd(8'(8'h90 + 4*k), 2'd2, 1'b0));
    rdchk("R6 confirm not stored", 8'hA0, 2'd2, 32'hFFFF_FFFF);

    // R7: write protection
    wr_protect = 1'b1;
    wr(8'h00, 2'd0, 32'h50);
    wr(8'hB0, 2'd0, 32'h40);
    wr(8'hB0, 2'd2, 32'h1234_5678);
    rdchk("R7 program error", 8'h00, 2'd0, 32'h90);
    wr(8'h00, 2'd0, 32'hFF);
    rdchk("R7 program blocked", 8'hB0, 2'd2, 32'hFFFF_FFFF);
    wr(8'h00, 2'd0, 32'h50);
    wr(8'h04, 2'd0, 32'h20);
    wr(8'h04, 2'd0, 32'hD0);
    chk("R7 no sweep", {31'b0, req_ready}, 32'd1);
    rdchk("R7 erase error", 8'h00, 2'd0, 32'hA0);
    wr(8'h00, 2'd0, 32'hFF);
    rdchk("R7 erase blocked", 8'h00, 2'd2, model_rd(8'h00, 2'd2, 1'b0));
    wr(8'h00, 2'd0, 32'h50);
    wr(8'hB4, 2'd0, 32'hE8);
    wr(8'hB4, 2'd1, 32'h0);
    wr(8'hB4, 2'd2, 32'h1122_3344);
    wr(8'hB4, 2'd0, 32'hD0);
    rdchk("R7 buffer error", 8'h00, 2'd0, 32'h90);
    wr(8'h00, 2'd0, 32'hFF);
    rdchk("R7 buffer blocked", 8'hB4, 2'd2, 32'hFFFF_FFFF);
    wr_protect = 1'b0;

    // R9: identifier read over every index
    wr(8'h00, 2'd0, 32'h90);
    for (int i = 0; i < 64; i++)
      for (int s = 0; s < 3; s++)
        rdchk("R9 ident", 8'(4*i), 2'(s),
              rep((i == 0) ? 16'h0089 : (i == 1) ? 16'h0018 : 16'h0, 2'(s)));
    wr(8'h00, 2'd0, 32'hFF);

    // R10: query table over every index, ignored writes
    wr(8'h00, 2'd0, 32'h98);
    for (int i = 0; i < 64; i++)
      for (int s = 0; s < 3; s++)
        rdchk("R10 query", 8'(4*i), 2'(s), rep({8'h00, qry_exp(i)}, 2'(s)));
    wr(8'h40, 2'd0, 32'h70);
    wr(8'h40, 2'd0, 32'h40);
    wr(8'h40, 2'd2, 32'h0);
    rdchk("R10 still query", 8'h40, 2'd0, 32'h51);
    wr(8'h00, 2'd0, 32'hFF);
    rdchk("R10 array intact", 8'h40, 2'd2, model_rd(8'h40, 2'd2, 1'b0));

    // R12: lock sequences
    wr(8'h00, 2'd0, 32'h50);
    wr(8'h00, 2'd0, 32'h60);
    rdchk("R12 pending status", 8'h00, 2'd1, 32'h0000);
    wr(8'h00, 2'd0, 32'h01);
    rdchk("R12 done by 01", 8'h00, 2'd0, 32'h80);
    wr(8'h00, 2'd0, 32'h50);
    wr(8'h00, 2'd0, 32'h60);
    wr(8'h00, 2'd0, 32'hD0);
    rdchk("R12 done by D0", 8'h00, 2'd1, 32'h0080);
    wr(8'h00, 2'd0, 32'h60);
    wr(8'h00, 2'd0, 32'h33);
    rdchk("R12 bad byte to array", 8'h08, 2'd2, model_rd(8'h08, 2'd2, 1'b0));

    // R11: status select, unknown command, clear
    wr(8'h00, 2'd0, 32'h70);
    rdchk("R11 status select", 8'h00, 2'd0, 32'h80);
    wr(8'h00, 2'd0, 32'h33);
    rdchk("R11 unknown to array", 8'h0C, 2'd2, model_rd(8'h0C, 2'd2, 1'b0));
    wr(8'h00, 2'd0, 32'h50);
    rdchk("R11 clear to array", 8'h0C, 2'd0, model_rd(8'h0C, 2'd0, 1'b0));
    wr(8'h00, 2'd0, 32'h70);
    rdchk("R11 cleared status", 8'h00, 2'd2, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule